// File: doc/BRIEF.md
# Iterative HI/LO Multiply-Divide Unit

This block is a sequential 32-bit integer multiply and divide engine for a processor datapath. A one-cycle start pulse launches one of four operations on two operands: signed multiply, unsigned multiply, signed divide or unsigned divide. The unit then works one bit per clock. Multiplication adds the multiplicand into the upper half of a double-width product and shifts right. Division shifts left, trial-subtracts and restores.

Results go to a pair of result registers, HI and LO. A multiply leaves the 64-bit product split across the two. A divide leaves the remainder in HI and the quotient in LO. Signed operations run the unsigned algorithm on operand magnitudes and correct the signs once the last step is done. No overflow or division by zero is trapped. A zero divisor still gives a fixed result in the normal time.

Top module: `seq_muldiv`

## Requirements
- R1: With `op_i` = 2'b01 (unsigned multiply), HI holds bits 63..32 and LO holds bits 31..0 of the unsigned product of `a_i` and `b_i`.
- R2: With `op_i` = 2'b00 (signed multiply), HI:LO holds the 64-bit two's complement product of the operands taken as signed values.
- R3: With `op_i` = 2'b11 (unsigned divide), LO holds the quotient and HI holds the remainder of `a_i` divided by `b_i`.
- R4: With `op_i` = 2'b10 (signed divide), the quotient in LO is rounded toward zero and the remainder in HI takes the sign of the dividend.
- R5: A divide with `b_i` = 0, signed or unsigned, completes in the normal cycle count and leaves LO all ones and HI equal to `a_i`.
- R6: A start accepted while idle raises `busy_o` from the next cycle for exactly 32 cycles. `done_o` is then high for exactly one cycle, the cycle right after the last busy cycle, and HI/LO are already valid in that cycle.
- R7: A start pulse while `busy_o` is high is ignored: the running operation keeps its operands, its result and its timing.
- R8: HI and LO keep their values, including during a later operation, until the cycle in which that operation's `done_o` is high.
- R9: After reset, `busy_o` and `done_o` are low and HI and LO read zero.
- R10: No overflow check is made: a signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch pulse, taken only while idle |
| op_i | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| a_i | input | 32 | Multiplicand or dividend |
| b_i | input | 32 | Multiplier or divisor |
| busy_o | output | 1 | High during the 32 iteration cycles |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | HI result register |
| lo_o | output | 32 | LO result register |

## Verification
A corrupted iteration counter shows up at the ports at once as a busy window other than 32 cycles. A wrong partial product or partial remainder only becomes visible when the operation completes, 33 cycles after start, as a wrong HI/LO value. A sign-correction fault appears only for operand sign combinations that need it. The directed cases therefore cover every sign pairing, extreme magnitudes and zero divisors. A start that leaks through while busy shows as a changed result or shifted done pulse in the same operation.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
   typedef enum logic [1:0] {
      OP_MUL_S = 2'b00,
      OP_MUL_U = 2'b01,
      OP_DIV_S = 2'b10,
      OP_DIV_U = 2'b11
   } md_op_e;

   function automatic logic op_is_div(input logic [1:0] op);
      return op[1];
   endfunction

   function automatic logic op_is_signed(input logic [1:0] op);
      return ~op[0];
   endfunction
endpackage

// File: rtl/muldiv_prep.sv
module muldiv_prep #(
   parameter int W = 32
) (
   input  logic [1:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] mag_a,
   output logic [W-1:0] mag_b,
   output logic         sgn_op,
   output logic         a_neg,
   output logic         signs_differ,
   output logic         b_zero
);
   import muldiv_pkg::*;

   logic a_msb_neg, b_msb_neg;

   assign sgn_op    = op_is_signed(op);
   assign a_msb_neg = sgn_op & a[W-1];
   assign b_msb_neg = sgn_op & b[W-1];

   always_comb begin
      mag_a = a_msb_neg ? (~a + 1'b1) : a;
      mag_b = b_msb_neg ? (~b + 1'b1) : b;
   end

   assign a_neg        = a_msb_neg;
   assign signs_differ = a_msb_neg ^ b_msb_neg;
   assign b_zero       = (b == '0);
endmodule

// File: rtl/muldiv_mul_step.sv
module muldiv_mul_step #(
   parameter int W = 32
) (
   input  logic [2*W-1:0] work,
   input  logic [W-1:0]   mcand,
   output logic [2*W-1:0] work_nx
);
   logic [W:0] upper_sum;

   always_comb begin
      if (work[0]) upper_sum = {1'b0, work[2*W-1:W]} + {1'b0, mcand};
      else         upper_sum = {1'b0, work[2*W-1:W]};
      work_nx = {upper_sum, work[W-1:1]};
   end
endmodule

// File: rtl/muldiv_div_step.sv
module muldiv_div_step #(
   parameter int W = 32
) (
   input  logic [2*W-1:0] work,
   input  logic [W-1:0]   divisor,
   output logic [2*W-1:0] work_nx
);
   logic [W:0]   shifted;
   logic [W+1:0] trial;
   logic         qbit;

   always_comb begin
      shifted = {work[2*W-1:W], work[W-1]};
      trial   = {1'b0, shifted} - {2'b00, divisor};
      qbit    = ~trial[W+1];
      if (qbit) work_nx = {trial[W-1:0],   work[W-2:0], 1'b1};
      else      work_nx = {shifted[W-1:0], work[W-2:0], 1'b0};
   end
endmodule

// File: rtl/muldiv_fix.sv
module muldiv_fix #(
   parameter int W = 32
) (
   input  logic [2*W-1:0] work,
   input  logic           is_div,
   input  logic           sgn_op,
   input  logic           a_neg,
   input  logic           signs_differ,
   input  logic           b_zero,
   output logic [W-1:0]   hi,
   output logic [W-1:0]   lo
);
   logic [2*W-1:0] prod;
   logic [W-1:0]   quot, rem;

   always_comb begin
      prod = (sgn_op && signs_differ) ? (~work + 1'b1) : work;
      quot = (sgn_op && signs_differ && !b_zero) ? (~work[W-1:0] + 1'b1) : work[W-1:0];
      rem  = (sgn_op && a_neg) ? (~work[2*W-1:W] + 1'b1) : work[2*W-1:W];
      if (is_div) begin
         hi = rem;
         lo = quot;
      end else begin
         hi = prod[2*W-1:W];
         lo = prod[W-1:0];
      end
   end
endmodule

// File: rtl/seq_muldiv.sv
module seq_muldiv #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [1:0]   op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] hi_o,
   output logic [W-1:0] lo_o
);
   import muldiv_pkg::*;

   localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

   if (W < 2) begin : g_bad_width
      $error("seq_muldiv: W must be at least 2");
   end

   logic [W-1:0]   mag_a, mag_b;
   logic           p_sgn, p_aneg, p_diff, p_bzero;

   logic           busy_q, done_q, div_q, sgn_q, aneg_q, diff_q, bzero_q;
   logic [CNT_W-1:0] cnt_q;
   logic [W-1:0]   opnd_q, hi_q, lo_q;
   logic [2*W-1:0] work_q, mul_nx, div_nx, step_nx;
   logic [W-1:0]   fix_hi, fix_lo;
   logic           accept, last;

   muldiv_prep #(.W(W)) u_prep (
      .op(op_i), .a(a_i), .b(b_i),
      .mag_a(mag_a), .mag_b(mag_b),
      .sgn_op(p_sgn), .a_neg(p_aneg),
      .signs_differ(p_diff), .b_zero(p_bzero)
   );

   muldiv_mul_step #(.W(W)) u_mul (
      .work(work_q), .mcand(opnd_q), .work_nx(mul_nx)
   );

   muldiv_div_step #(.W(W)) u_div (
      .work(work_q), .divisor(opnd_q), .work_nx(div_nx)
   );

   assign step_nx = div_q ? div_nx : mul_nx;

   muldiv_fix #(.W(W)) u_fix (
      .work(step_nx), .is_div(div_q), .sgn_op(sgn_q),
      .a_neg(aneg_q), .signs_differ(diff_q), .b_zero(bzero_q),
      .hi(fix_hi), .lo(fix_lo)
   );

   assign accept = start_i && !busy_q;
   assign last   = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         cnt_q   <= '0;
         div_q   <= 1'b0;
         sgn_q   <= 1'b0;
         aneg_q  <= 1'b0;
         diff_q  <= 1'b0;
         bzero_q <= 1'b0;
         opnd_q  <= '0;
         work_q  <= '0;
         hi_q    <= '0;
         lo_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q  <= 1'b1;
            cnt_q   <= '0;
            div_q   <= op_is_div(op_i);
            sgn_q   <= p_sgn;
            aneg_q  <= p_aneg;
            diff_q  <= p_diff;
            bzero_q <= p_bzero;
            opnd_q  <= op_is_div(op_i) ? mag_b : mag_a;
            work_q  <= {{W{1'b0}}, (op_is_div(op_i) ? mag_a : mag_b)};
         end else if (busy_q) begin
            work_q <= step_nx;
            cnt_q  <= cnt_q + 1'b1;
            if (last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               hi_q   <= fix_hi;
               lo_q   <= fix_lo;
            end
         end
      end
   end

   assign busy_o = busy_q;
   assign done_o = done_q;
   assign hi_o   = hi_q;
   assign lo_o   = lo_q;

   // R6: completion pulse only right after a busy cycle, and only one cycle long
   a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $past(busy_q));
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   a_r6_count_starts_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> cnt_q == '0);
   // R7: operation in flight keeps running with its operand
   a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !last) |=> (busy_q && $stable(opnd_q)));
   // R8: results move only on completion
   a_r8_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |-> ($stable(hi_q) && $stable(lo_q)));
   // R3: partial remainder stays below a nonzero divisor
   a_r3_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && div_q && opnd_q != '0) |-> (work_q[2*W-1:W] < opnd_q));
   // R5: zero divisor yields an all-ones quotient
   a_r5_div_zero_quot: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && div_q && bzero_q) |-> (lo_q == '1));
endmodule

// File: tb/seq_muldiv_test.sv
module seq_muldiv_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  op_i = 2'b00;
   logic [31:0] a_i = '0, b_i = '0;
   logic        busy_o, done_o;
   logic [31:0] hi_o, lo_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   seq_muldiv uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
      .hi_o(hi_o), .lo_o(lo_o)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
      logic [63:0] p;
      logic signed [31:0] sq, sr;
      case (op)
         2'b01: p = {32'd0, a} * {32'd0, b};
         2'b00: p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
         2'b11: p = (b == 0) ? {a, 32'hFFFF_FFFF} : {a % b, a / b};
         default: begin
            if (b == 0) p = {a, 32'hFFFF_FFFF};
            else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) p = {32'd0, 32'h8000_0000};
            else begin
               sq = $signed(a) / $signed(b);
               sr = $signed(a) % $signed(b);
               p = {sr, sq};
            end
         end
      endcase
      return p;
   endfunction

   // Runs one operation, checks busy length, done pulse and HI:LO
   task automatic run_op(input string req, input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
      int n = 0;
      @(negedge clk);
      op_i = op; a_i = a; b_i = b; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (busy_o && n < 100) begin
         n++;
         @(negedge clk);
      end
      check({req, " R6 busy cycles"}, 64'(n), 64'd32);
      check({req, " R6 done"}, 64'(done_o), 64'd1);
      check(req, {hi_o, lo_o}, model(op, a, b));
      @(negedge clk);
      check({req, " R6 done one cycle"}, 64'(done_o), 64'd0);
   endtask

   task automatic t_reset;
      check("R9 busy", 64'(busy_o), 64'd0);
      check("R9 done", 64'(done_o), 64'd0);
      check("R9 hilo", {hi_o, lo_o}, 64'd0);
   endtask

   task automatic t_mul_unsigned;
      run_op("R1 mulu", 2'b01, 32'd11, 32'd13);
      run_op("R1 mulu max", 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      run_op("R1 mulu zero", 2'b01, 32'h1234_5678, 32'd0);
   endtask

   task automatic t_mul_signed;
      run_op("R2 muls neg*pos", 2'b00, 32'hFFFF_FFF9, 32'd6);
      run_op("R2 muls neg*neg", 2'b00, 32'h8000_0000, 32'h8000_0000);
      run_op("R2 muls pos*neg", 2'b00, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
   endtask

   task automatic t_div_unsigned;
      run_op("R3 divu", 2'b11, 32'd147, 32'd11);
      run_op("R3 divu big", 2'b11, 32'hFFFF_FFFF, 32'h8000_0001);
      run_op("R3 divu small", 2'b11, 32'd5, 32'd9);
   endtask

   task automatic t_div_signed;
      run_op("R4 divs neg/pos", 2'b10, 32'hFFFF_FFF9, 32'd2);
      run_op("R4 divs pos/neg", 2'b10, 32'd7, 32'hFFFF_FFFE);
      run_op("R4 divs neg/neg", 2'b10, 32'hFFFF_FFF9, 32'hFFFF_FFFE);
   endtask

   task automatic t_div_zero;
      run_op("R5 divu by zero", 2'b11, 32'hDEAD_BEEF, 32'd0);
      run_op("R5 divs by zero neg", 2'b10, 32'hFFFF_FF00, 32'd0);
      run_op("R5 divs by zero pos", 2'b10, 32'd1234, 32'd0);
   endtask

   task automatic t_overflow;
      run_op("R10 divs overflow", 2'b10, 32'h8000_0000, 32'hFFFF_FFFF);
   endtask

   // Second start mid-run must not disturb the first operation; old HI/LO hold meanwhile
   task automatic t_ignore_and_hold;
      int n = 0;
      logic [63:0] prev;
      prev = {hi_o, lo_o};
      @(negedge clk);
      op_i = 2'b01; a_i = 32'd1000; b_i = 32'd3000; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (5) begin n++; @(negedge clk); end
      op_i = 2'b11; a_i = 32'd9; b_i = 32'd2; start_i = 1'b1;
      @(negedge clk);
      n++;
      start_i = 1'b0;
      check("R8 hold during busy", {hi_o, lo_o}, prev);
      while (busy_o && n < 100) begin n++; @(negedge clk); end
      check("R7 busy cycles", 64'(n), 64'd32);
      check("R7 result of first op", {hi_o, lo_o}, 64'd3_000_000);
      @(negedge clk);
      check("R7 no second run", 64'(busy_o), 64'd0);
      repeat (3) @(negedge clk);
      check("R8 hold idle", {hi_o, lo_o}, 64'd3_000_000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mul_unsigned();
      t_mul_signed();
      t_div_unsigned();
      t_div_signed();
      t_div_zero();
      t_overflow();
      t_ignore_and_hold();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule